// File: doc/BRIEF.md
# Auto-Increment Register Access Port

This block is the byte-level register front end of a 24-pin I/O expander. It sits behind a serial slave interface that has already decoded a transaction into three things: one command byte, then a sequence of write bytes or read requests. The command byte loads an internal register pointer and an auto-increment flag. Every data byte that follows accesses the register under the pointer. With auto-increment set, the pointer then moves to the next implemented address.

The register space is sparse. Per-port registers sit in groups of three at 4-aligned bases. The extended bank starts at 0x40 and also holds some two-byte-per-port groups and a few single bytes. The block decodes every address into one of four classes: unimplemented, read-only, write-only or read/write. Writes to non-writable addresses are dropped. Reads of non-readable addresses return 0x00 and raise no strobe. Downstream register logic receives registered write commands and a one-cycle read strobe with the address, so that it can apply read side effects. It returns read data combinationally.

Write bytes and read requests arrive as valid/ready streams, and read data leaves on a valid/ready stream. A byte is taken on any cycle where valid and ready are both high. The response holds one entry. While that entry is valid and the sink holds `rsp_ready` low, the response data stays fixed and no new read request is accepted. The command strobe is a plain control pin and has no handshake.

Top module: `xpx_reg_port`

## Requirements
- R1: After reset the pointer is 0x00 and auto-increment is off, `rsp_valid` and `reg_wr_en` are low. A read issued before any command accesses 0x00 and does not advance.
- R2: A command byte sets the pointer to bits 6:0 of the byte. Bit 7 of the byte enables auto-increment.
- R3: An accepted write byte to a writable address gives `reg_wr_en` high for exactly the next cycle, with that address and the data byte.
- R4: Writes to read-only addresses (0x00–0x02, 0x58–0x5A, 0x6C–0x6E) and to unimplemented addresses give no `reg_wr_en`.
- R5: An accepted read request to a readable address pulses `reg_rd_stb` in the accept cycle with the pointer on `reg_rd_addr`. The next cycle `rsp_valid` is high and `rsp_data` carries `reg_rd_data`. Reads of the write-only bytes 0x68–0x6A and of unimplemented addresses give no strobe and a response of 0x00.
- R6: At the output mode byte 0x5C only bits 2:0 are meaningful. Write data is masked to those bits, and read data is masked the same way.
- R7: With auto-increment, the pointer skips gaps to the next implemented address. Examples: 0x02→0x04, 0x0E→0x40, 0x45→0x48, 0x5A→0x5C, 0x5C→0x60, 0x65→0x68, 0x72→0x74, 0x75→0x76.
- R8: With auto-increment, the pointer wraps from 0x76 to 0x00.
- R9: Without auto-increment, every data byte of the transaction accesses the same address.
- R10: At most 52 data bytes per transaction take effect. Later bytes are accepted but give no write, no strobe and a 0x00 response, until the next command.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `rq_ready` is low.
- R12: `cmd_valid` blocks both data streams (`wr_ready` and `rq_ready` low). A pending write byte blocks read requests (`rq_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Bit 7 auto-increment, bits 6:0 start address |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte ready |
| wr_data | input | 8 | Write byte |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| reg_wr_en | output | 1 | Registered write command to register logic |
| reg_wr_addr | output | 7 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd_stb | output | 1 | One-cycle read strobe |
| reg_rd_addr | output | 7 | Read address |
| reg_rd_data | input | 8 | Read data from register logic (combinational) |

## Verification
Auto-increment read walks start just before each gap and at the top of the map. They show whether the pointer lands on the right implemented address and whether the read-permission check follows it across a write-only group. Non-incrementing writes to read-only, unimplemented and mode addresses separate write suppression from masking. A 53-byte burst marks the exact byte where the transfer budget runs out. A stalled response and simultaneous requests separate the back-pressure rule from the priority between command, write and read.

// File: rtl/xpx_pkg.sv
package xpx_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int MAP_SPAN = 'h77;          // addresses 0x00..0x76
  localparam logic [ADDR_W-1:0] MODE_ADDR = 7'h5C;
  localparam logic [DATA_W-1:0] MODE_MASK = 8'h07;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_WO   = 2'b10,
    ACC_RW   = 2'b11
  } acc_kind_e;

  function automatic logic addr_impl(input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    if (a <= 7'h0E)                       r = (a[1:0] != 2'b11);
    else if (a >= 7'h40 && a <= 7'h45)    r = 1'b1;
    else if (a >= 7'h48 && a <= 7'h5A)    r = (a[1:0] != 2'b11);
    else if (a == MODE_ADDR)              r = 1'b1;
    else if (a >= 7'h60 && a <= 7'h65)    r = 1'b1;
    else if (a >= 7'h68 && a <= 7'h72)    r = (a[1:0] != 2'b11);
    else if (a >= 7'h74 && a <= 7'h76)    r = 1'b1;
    return r;
  endfunction

  function automatic acc_kind_e addr_kind(input logic [ADDR_W-1:0] a);
    acc_kind_e k;
    if (!addr_impl(a))                                   k = ACC_NONE;
    else if (a <= 7'h02)                                 k = ACC_RO;
    else if (a >= 7'h58 && a <= 7'h5A)                   k = ACC_RO;
    else if (a >= 7'h6C && a <= 7'h6E)                   k = ACC_RO;
    else if (a >= 7'h68 && a <= 7'h6A)                   k = ACC_WO;
    else                                                 k = ACC_RW;
    return k;
  endfunction

  // Next implemented address strictly above a, wrapping past the map top.
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] res;
    logic              hit;
    int                c;
    res = '0;
    hit = 1'b0;
    for (int i = 1; i <= MAP_SPAN; i++) begin
      c = (int'(a) + i) % MAP_SPAN;
      if (!hit && addr_impl(ADDR_W'(c))) begin
        res = ADDR_W'(c);
        hit = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/xpx_ptr_ctl.sv
module xpx_ptr_ctl
  import xpx_pkg::*;
#(
  parameter int BURST_MAX = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              acc_fire,
  output logic [ADDR_W-1:0] ptr,
  output logic              in_budget
);
  localparam int CNT_W = $clog2(BURST_MAX + 1);

  logic             ai_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_budget = (cnt_q < CNT_W'(BURST_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      ai_q  <= 1'b0;
      cnt_q <= '0;
    end else if (cmd_valid) begin
      ptr   <= cmd_byte[ADDR_W-1:0];
      ai_q  <= cmd_byte[DATA_W-1];
      cnt_q <= '0;
    end else if (acc_fire && in_budget) begin
      cnt_q <= cnt_q + 1'b1;
      if (ai_q) ptr <= addr_next(ptr);
    end
  end
endmodule

// File: rtl/xpx_wr_path.sv
module xpx_wr_path
  import xpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              allowed,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);
  logic [DATA_W-1:0] data_m;
  assign data_m = (ptr == MODE_ADDR) ? (data & MODE_MASK) : data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= wr_fire && allowed;
      if (wr_fire && allowed) begin
        reg_wr_addr <= ptr;
        reg_wr_data <= data_m;
      end
    end
  end
endmodule

// File: rtl/xpx_rd_path.sv
module xpx_rd_path
  import xpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_fire,
  input  logic              allowed,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              rsp_ready,
  output logic              reg_rd_stb,
  output logic [ADDR_W-1:0] reg_rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] rd_m;

  assign reg_rd_stb  = rq_fire && allowed;
  assign reg_rd_addr = ptr;

  always_comb begin
    if (!allowed)               rd_m = '0;
    else if (ptr == MODE_ADDR)  rd_m = reg_rd_data & MODE_MASK;
    else                        rd_m = reg_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rq_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_m;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xpx_reg_port.sv
module xpx_reg_port
  import xpx_pkg::*;
#(
  parameter int BURST_MAX = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rq_valid,
  output logic              rq_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_stb,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);
  logic [ADDR_W-1:0] ptr;
  logic              in_budget;
  logic              wr_fire, rq_fire;
  acc_kind_e         kind;
  logic              can_wr, can_rd;

  assign wr_ready = !cmd_valid;
  assign rq_ready = !cmd_valid && !wr_valid && (!rsp_valid || rsp_ready);
  assign wr_fire  = wr_valid && wr_ready;
  assign rq_fire  = rq_valid && rq_ready;

  assign kind   = addr_kind(ptr);
  assign can_wr = in_budget && (kind == ACC_RW || kind == ACC_WO);
  assign can_rd = in_budget && (kind == ACC_RW || kind == ACC_RO);

  xpx_ptr_ctl #(.BURST_MAX(BURST_MAX)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .acc_fire(wr_fire || rq_fire), .ptr(ptr), .in_budget(in_budget)
  );

  xpx_wr_path u_wr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .allowed(can_wr),
    .ptr(ptr), .data(wr_data), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  xpx_rd_path u_rd (
    .clk(clk), .rst_n(rst_n), .rq_fire(rq_fire), .allowed(can_rd),
    .ptr(ptr), .reg_rd_data(reg_rd_data), .rsp_ready(rsp_ready),
    .reg_rd_stb(reg_rd_stb), .reg_rd_addr(reg_rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/xpx_reg_port_chk.sv
module xpx_reg_port_chk
  import xpx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              reg_rd_stb,
  input logic [ADDR_W-1:0] reg_rd_addr
);
  assert_wr_target_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (addr_kind(reg_wr_addr) == ACC_RW || addr_kind(reg_wr_addr) == ACC_WO));

  assert_stb_target_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |-> (rq_valid && rq_ready &&
                    (addr_kind(reg_rd_addr) == ACC_RW || addr_kind(reg_rd_addr) == ACC_RO)));

  assert_rsp_after_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=> rsp_valid);

  assert_mode_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == MODE_ADDR) |-> (reg_wr_data & ~MODE_MASK) == '0);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stall_blocks_rq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rq_ready);

  assert_cmd_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!wr_ready && !rq_ready));
endmodule

bind xpx_reg_port xpx_reg_port_chk u_chk (.*);

// File: tb/test_xpx_reg_port.sv
`timescale 1ns/1ps
module test_xpx_reg_port;
  localparam int BURST = 52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       rq_valid = 1'b0;
  logic       rq_ready;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       reg_wr_en;
  logic [6:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic       reg_rd_stb;
  logic [6:0] reg_rd_addr;
  logic [7:0] reg_rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  // downstream register model: data is a fixed function of the address
  assign reg_rd_data = {1'b0, reg_rd_addr} ^ 8'h5A;

  xpx_reg_port #(.BURST_MAX(BURST)) i_xpx_reg_port (.*);

  function automatic bit tb_readable(input logic [6:0] a);
    return (a <= 7'h0E && a[1:0] != 3) || (a >= 7'h40 && a <= 7'h45) ||
           (a >= 7'h48 && a <= 7'h5A && a[1:0] != 3) || a == 7'h5C ||
           (a >= 7'h60 && a <= 7'h65) || (a >= 7'h6C && a <= 7'h72 && a[1:0] != 3) ||
           (a >= 7'h74 && a <= 7'h76);
  endfunction

  function automatic logic [7:0] tb_exp_rd(input logic [6:0] a);
    logic [7:0] v;
    v = {1'b0, a} ^ 8'h5A;
    if (!tb_readable(a)) return 8'h00;
    if (a == 7'h5C) return v & 8'h07;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, input bit exp_en,
                          input logic [6:0] exp_a, input logic [7:0] exp_d, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    chk(reg_wr_en == exp_en, {tag, " wr_en"}, reg_wr_en, exp_en);
    if (exp_en) begin
      chk(reg_wr_addr == exp_a, {tag, " wr_addr"}, reg_wr_addr, exp_a);
      chk(reg_wr_data == exp_d, {tag, " wr_data"}, reg_wr_data, exp_d);
    end
  endtask

  task automatic do_read(input logic [6:0] exp_a, input bit force_zero, input string tag);
    bit stb_exp;
    @(negedge clk);
    rq_valid = 1'b1;
    #1;
    stb_exp = tb_readable(exp_a) && !force_zero;
    chk(reg_rd_stb == stb_exp, {tag, " rd_stb"}, reg_rd_stb, stb_exp);
    chk(reg_rd_addr == exp_a, {tag, " rd_addr"}, reg_rd_addr, exp_a);
    @(posedge clk);
    @(negedge clk);
    rq_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_data == (force_zero ? 8'h00 : tb_exp_rd(exp_a)), {tag, " rsp_data"},
        rsp_data, force_zero ? 0 : tb_exp_rd(exp_a));
  endtask

  typedef struct packed {
    logic [6:0] start;
    logic [6:0] nxt;
  } step_t;

  localparam step_t STEPS [10] = '{
    '{7'h02, 7'h04}, '{7'h0E, 7'h40}, '{7'h45, 7'h48}, '{7'h5A, 7'h5C},
    '{7'h5C, 7'h60}, '{7'h65, 7'h68}, '{7'h72, 7'h74}, '{7'h75, 7'h76},
    '{7'h76, 7'h00}, '{7'h4E, 7'h50}
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(reg_wr_en == 1'b0, "R1 wr_en after reset", reg_wr_en, 0);
    @(negedge clk); rst_n = 1'b1;
    do_read(7'h00, 1'b0, "R1 first read at 0x00");
    do_read(7'h00, 1'b0, "R1 no advance before command");

    // R7 R8 R2: table of auto-increment steps
    foreach (STEPS[i]) begin
      send_cmd({1'b1, STEPS[i].start});
      do_read(STEPS[i].start, 1'b0, "R2 walk start");
      do_read(STEPS[i].nxt, 1'b0, STEPS[i].start == 7'h76 ? "R8 wrap" : "R7 skip");
    end

    // R3 write with auto-increment
    send_cmd(8'h85);
    do_write(8'hA1, 1'b1, 7'h05, 8'hA1, "R3 write 0x05");
    do_write(8'h3C, 1'b1, 7'h06, 8'h3C, "R3 write 0x06");

    // R9 no auto-increment
    send_cmd(8'h09);
    do_write(8'h11, 1'b1, 7'h09, 8'h11, "R9 first");
    do_write(8'h22, 1'b1, 7'h09, 8'h22, "R9 same address");

    // R4 dropped writes
    send_cmd(8'h01);
    do_write(8'hFF, 1'b0, 7'h00, 8'h00, "R4 read-only input");
    send_cmd(8'h59);
    do_write(8'hFF, 1'b0, 7'h00, 8'h00, "R4 read-only int status");
    send_cmd(8'h6D);
    do_write(8'hFF, 1'b0, 7'h00, 8'h00, "R4 read-only input status");
    send_cmd(8'h07);
    do_write(8'hFF, 1'b0, 7'h00, 8'h00, "R4 unimplemented");

    // R5 write-only and unimplemented reads
    send_cmd(8'h69);
    do_read(7'h69, 1'b0, "R5 write-only read");
    do_write(8'h04, 1'b1, 7'h69, 8'h04, "R5 write-only accepts write");
    send_cmd(8'h3F);
    do_read(7'h3F, 1'b0, "R5 unimplemented read");

    // R6 mode byte masking
    send_cmd(8'h5C);
    do_write(8'hFF, 1'b1, 7'h5C, 8'h07, "R6 write mask");
    do_read(7'h5C, 1'b0, "R6 read mask");

    // R10 burst budget
    send_cmd(8'h04);
    for (int k = 0; k < BURST; k++)
      do_write(8'(k), 1'b1, 7'h04, 8'(k), "R10 within budget");
    do_write(8'hEE, 1'b0, 7'h00, 8'h00, "R10 beyond budget write");
    do_read(7'h04, 1'b1, "R10 beyond budget read");
    send_cmd(8'h04);
    do_write(8'h77, 1'b1, 7'h04, 8'h77, "R10 budget restored");

    // R11 back-pressure
    send_cmd(8'h40);
    rsp_ready = 1'b0;
    do_read(7'h40, 1'b0, "R11 stalled read");
    @(negedge clk); #1;
    chk(rsp_valid == 1'b1, "R11 rsp held valid", rsp_valid, 1);
    chk(rsp_data == tb_exp_rd(7'h40), "R11 rsp data held", rsp_data, tb_exp_rd(7'h40));
    chk(rq_ready == 1'b0, "R11 rq_ready low", rq_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R11 rsp drained", rsp_valid, 0);

    // R12 priority
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'h40; wr_valid = 1'b1; rq_valid = 1'b1;
    #1;
    chk(wr_ready == 1'b0, "R12 cmd blocks write", wr_ready, 0);
    chk(rq_ready == 1'b0, "R12 cmd blocks read", rq_ready, 0);
    cmd_valid = 1'b0;
    #0.5;
    chk(wr_ready == 1'b1, "R12 write ready", wr_ready, 1);
    chk(rq_ready == 1'b0, "R12 write blocks read", rq_ready, 0);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rq_valid = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule